// File: doc/BRIEF.md
# Programmable-Table ALU

This block is an n-bit arithmetic and logic unit in which every operation uses the same datapath. For each bit, a small function cell reads the two operand bits and looks up two values, a propagate P and a generate G, in a pair of four-entry truth tables. A decoder fills these tables from the opcode. One shared carry chain then resolves the carries with c(i+1) = G(i) | P(i)·c(i). An output stage forms each result bit either as P XOR carry (arithmetic) or as P alone (logic).

For addition, the tables hold the usual lookahead propagate and generate. For subtraction, they hold the same functions with b inverted, and the carry into bit 0 is forced to 1. For logic operations, G is held at zero and P holds the wanted two-input function, so any bitwise function of a and b costs one table entry and no extra gates.

A parameter selects how the carry chain is built: a ripple chain, or a fully expanded lookahead form in which each carry depends only on P, G and the carry input. Results are registered and appear one clock after the operands are presented.

Top module: `pg_alu`

## Requirements
- R1: Opcode 0 (ADD) gives {carry_out, result} = a + b + carry_in.
- R2: Opcode 1 (SUB) gives result = (a − b) mod 2^W and carry_out = 1 exactly when a ≥ b unsigned; carry_in has no effect.
- R3: Opcodes 2 (AND), 3 (OR), 4 (XOR), 5 (NOR) and 7 (NAND) give the named bitwise function of a and b.
- R4: Opcode 6 (PASS_A) gives result = a.
- R5: For every logic opcode (2 to 7), carry_out is 0 and carry_in has no effect on any output.
- R6: zero is 1 exactly when every bit of result is 0.
- R7: Outputs change one clock after the inputs are sampled: the values on a, b, opcode and carry_in at a rising edge set result, carry_out and zero from that edge onward.
- R8: While rst_n is low at a rising edge, result, carry_out and zero are cleared to 0 (synchronous, active low).
- R9: The ripple carry chain (LOOKAHEAD=0) and the expanded lookahead chain (LOOKAHEAD=1) give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| opcode | input | 3 | Operation select (0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 NOR, 6 PASS_A, 7 NAND) |
| carry_in | input | 1 | Carry into bit 0, used by ADD only |
| result | output | WIDTH | Registered result |
| carry_out | output | 1 | Registered carry out of the top bit |
| zero | output | 1 | Registered flag, high when result is all zeros |

## Verification
The assertions check, on every clock, the arithmetic results of ADD and SUB against plain integer sums of the operands from the previous cycle. They also check that logic opcodes leave carry_out low, that PASS_A copies a, that the zero flag matches the result, and that the carry chain yields no carry when G and the carry input are all zero. The bench's exhaustive sweep of a 4-bit configuration is what covers the bitwise table contents for every opcode. The same sweep shows that carry_in has no effect on SUB and the logic operations, and that the ripple and lookahead builds agree on every input.

// File: rtl/pg_alu_pkg.sv
// Package: shared opcode encoding and carry-input selection for the ALU.
// Assumes a 3-bit opcode; the encoding is visible at the top-level port.
package pg_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_AND   = 3'd2,
        OP_OR    = 3'd3,
        OP_XOR   = 3'd4,
        OP_NOR   = 3'd5,
        OP_PASSA = 3'd6,
        OP_NAND  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        CIN_EXT  = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_ZERO = 2'd2
    } cin_sel_e;

    localparam int TAB_BITS = 4;

endpackage

// File: rtl/pg_op_decode.sv
// Module: opcode decoder. Turns the opcode into the P and G truth tables
// (indexed by {a_i, b_i}), the effective carry into bit 0, and an arithmetic flag.
// Assumes the encoding in pg_alu_pkg; purely combinational.
module pg_op_decode
    import pg_alu_pkg::*;
(
    input  logic [2:0]          opcode,
    input  logic                carry_in,
    output logic [TAB_BITS-1:0] p_tab,
    output logic [TAB_BITS-1:0] g_tab,
    output logic                cin_eff,
    output logic                arith
);

    cin_sel_e cin_sel;

    // Table and carry selection for each opcode.
    always_comb begin
        p_tab   = 4'b0000;
        g_tab   = 4'b0000;
        cin_sel = CIN_ZERO;
        arith   = 1'b0;
        case (alu_op_e'(opcode))
            OP_ADD:   begin p_tab = 4'b0110; g_tab = 4'b1000; cin_sel = CIN_EXT; arith = 1'b1; end
            OP_SUB:   begin p_tab = 4'b1001; g_tab = 4'b0100; cin_sel = CIN_ONE; arith = 1'b1; end
            OP_AND:   p_tab = 4'b1000;
            OP_OR:    p_tab = 4'b1110;
            OP_XOR:   p_tab = 4'b0110;
            OP_NOR:   p_tab = 4'b0001;
            OP_PASSA: p_tab = 4'b1100;
            OP_NAND:  p_tab = 4'b0111;
            default:  p_tab = 4'b0000;
        endcase
    end

    // Effective carry into bit 0.
    always_comb begin
        case (cin_sel)
            CIN_EXT: cin_eff = carry_in;
            CIN_ONE: cin_eff = 1'b1;
            default: cin_eff = 1'b0;
        endcase
    end

    // Logic opcodes never generate.
    always_comb begin
        if (!arith) assert (g_tab == '0) else $error("p_logic_no_gen_r5");
    end

endmodule

// File: rtl/pg_cell.sv
// Module: per-bit function cell. Looks up P and G in two 4-entry tables
// indexed by {a_i, b_i}. Assumes the tables are steady during the cycle.
module pg_cell
    import pg_alu_pkg::*;
(
    input  logic                a_bit,
    input  logic                b_bit,
    input  logic [TAB_BITS-1:0] p_tab,
    input  logic [TAB_BITS-1:0] g_tab,
    output logic                p_bit,
    output logic                g_bit
);

    logic [1:0] idx;

    // Table lookup for this bit.
    always_comb begin
        idx   = {a_bit, b_bit};
        p_bit = p_tab[idx];
        g_bit = g_tab[idx];
    end

endmodule

// File: rtl/pg_carry.sv
// Module: carry chain. c[i+1] = g[i] | p[i] & c[i], built either as a ripple
// chain or as a fully expanded lookahead (LOOKAHEAD=1). Combinational.
module pg_carry #(
    parameter int WIDTH     = 16,
    parameter bit LOOKAHEAD = 1'b0
) (
    input  logic [WIDTH-1:0] p,
    input  logic [WIDTH-1:0] g,
    input  logic             cin,
    output logic [WIDTH:0]   c
);

    generate
        if (LOOKAHEAD) begin : g_cla
            // Each carry from its own sum of products of P, G and cin.
            always_comb begin
                c[0] = cin;
                for (int i = 0; i < WIDTH; i++) begin
                    logic run;
                    logic acc;
                    run = 1'b1;
                    acc = 1'b0;
                    for (int j = i; j >= 0; j--) begin
                        acc = acc | (g[j] & run);
                        run = run & p[j];
                    end
                    c[i+1] = acc | (run & cin);
                end
            end
        end else begin : g_ripple
            assign c[0] = cin;
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign c[i+1] = g[i] | (p[i] & c[i]);
            end
        end
    endgenerate

    // With no generate and no carry in, no carry can appear.
    always_comb begin
        if (g == '0 && !cin) assert (c == '0) else $error("p_no_spurious_carry_r5");
    end

endmodule

// File: rtl/pg_alu.sv
// Module: top of the table-driven ALU. Decodes the opcode into P/G tables,
// runs all bits through function cells and one carry chain, and registers
// result, carry_out and zero. Assumes synchronous active-low reset; latency 1.
module pg_alu
    import pg_alu_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter bit LOOKAHEAD = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [2:0]       opcode,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             zero
);

    localparam int CW = WIDTH + 1;

    logic [TAB_BITS-1:0] p_tab;
    logic [TAB_BITS-1:0] g_tab;
    logic                cin_eff;
    logic                arith;
    logic [WIDTH-1:0]    p_vec;
    logic [WIDTH-1:0]    g_vec;
    logic [CW-1:0]       c_vec;
    logic [WIDTH-1:0]    res_d;
    logic                cout_d;

    pg_op_decode u_dec (
        .opcode   (opcode),
        .carry_in (carry_in),
        .p_tab    (p_tab),
        .g_tab    (g_tab),
        .cin_eff  (cin_eff),
        .arith    (arith)
    );

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            pg_cell u_cell (
                .a_bit (a[i]),
                .b_bit (b[i]),
                .p_tab (p_tab),
                .g_tab (g_tab),
                .p_bit (p_vec[i]),
                .g_bit (g_vec[i])
            );
        end
    endgenerate

    pg_carry #(.WIDTH(WIDTH), .LOOKAHEAD(LOOKAHEAD)) u_carry (
        .p   (p_vec),
        .g   (g_vec),
        .cin (cin_eff),
        .c   (c_vec)
    );

    // Output unit: sum from P and carries, or P alone for logic.
    always_comb begin
        res_d  = arith ? (p_vec ^ c_vec[WIDTH-1:0]) : p_vec;
        cout_d = arith & c_vec[WIDTH];
    end

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            carry_out <= 1'b0;
            zero      <= 1'b0;
        end else begin
            result    <= res_d;
            carry_out <= cout_d;
            zero      <= (res_d == '0);
        end
    end

    p_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 3'd0) |=> ({carry_out, result} ==
            ({1'b0, $past(a)} + {1'b0, $past(b)} + {{WIDTH{1'b0}}, $past(carry_in)})));

    p_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 3'd1) |=> (result == WIDTH'($past(a) - $past(b))
            && carry_out == ($past(a) >= $past(b))));

    p_pass_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 3'd6) |=> (result == $past(a)));

    p_logic_cout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode >= 3'd2) |=> !carry_out);

    p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (zero == (result == '0)));

endmodule

// File: tb/sim_pg_alu.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of a 4-bit ALU, ripple (u0) and lookahead (u1),
// against arithmetic expected values.
module sim_pg_alu;

    localparam int W = 4;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [2:0]   opcode = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] res0, res1;
    logic         co0, co1, z0, z1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pg_alu #(.WIDTH(W), .LOOKAHEAD(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .opcode(opcode),
        .carry_in(carry_in), .result(res0), .carry_out(co0), .zero(z0));

    pg_alu #(.WIDTH(W), .LOOKAHEAD(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .opcode(opcode),
        .carry_in(carry_in), .result(res1), .carry_out(co1), .zero(z1));

    task automatic check(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%0d b=%0d cin=%0d actual=%h expected=%h",
                     req, opcode, a, b, carry_in, act, exp);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset clears outputs
        a = 4'hF; b = 4'hF; opcode = 3'd0; carry_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", {co0, z0, res0}, '0);
        check("R8", {co1, z1, res1}, '0);
        rst_n = 1'b1;
        for (int op = 0; op < 8; op++) begin
            for (int ci = 0; ci < 2; ci++) begin
                for (int x = 0; x < N; x++) begin
                    for (int y = 0; y < N; y++) begin
                        logic [W:0]   full;
                        logic [W-1:0] r;
                        logic         co;
                        string        req;
                        @(negedge clk);
                        a = W'(x); b = W'(y); opcode = 3'(op); carry_in = ci[0];
                        co = 1'b0;
                        case (op)
                            0: begin full = (W+1)'(x + y + ci); r = full[W-1:0]; co = full[W]; req = "R1"; end
                            1: begin r = W'(x - y); co = (x >= y); req = "R2"; end
                            2: begin r = W'(x & y); req = "R3_R5"; end
                            3: begin r = W'(x | y); req = "R3_R5"; end
                            4: begin r = W'(x ^ y); req = "R3_R5"; end
                            5: begin r = ~W'(x | y); req = "R3_R5"; end
                            6: begin r = W'(x); req = "R4_R5"; end
                            default: begin r = ~W'(x & y); req = "R3_R5"; end
                        endcase
                        // R7: result visible after the next rising edge
                        @(posedge clk);
                        @(negedge clk);
                        check(req, {co0, 1'b0, res0}, {co, 1'b0, r});
                        check("R6", {2'b00, z0, 1'b0} , {2'b00, (r == '0), 1'b0});
                        check("R9", {co1, z1, res1}, {co0, z0, res0});
                    end
                end
            end
        end
        // R8: synchronous reset mid-run clears a nonzero result
        a = 4'h5; b = 4'h2; opcode = 3'd0; carry_in = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7", {2'b00, res0}, {2'b00, 4'h7});
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8", {co0, z0, res0}, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule